// File: doc/BRIEF.md
# Snoop Inquire Writeback Address Tracker

This block sits on the system side of a processor bus. It runs an inquire (snoop) cycle against the processor's cache and then follows any writeback of a modified line that the inquire triggers. A requester asks for an inquire with a line address and an optional invalidate flag. The block pulses the external-address strobe toward the processor and drives the invalidate request in that same cycle. It samples the processor's hit and modified-hit replies at the fixed response point. When the line is modified, it waits for the processor's address strobe that opens the writeback.

The block has to know the address of every beat of the writeback, and it can get that address from one of two places. If the system holds the address bus (address hold asserted) when the writeback starts, the processor does not drive the upper address lines, so the block uses the inquire address it latched when the snoop began. If address hold has been released, the processor drives the starting address, and the block captures it from the bus at the address strobe. In both cases only the start of the burst is known. The block produces the remaining beat addresses itself in interleaved order. The writeback counts as finished when modified-hit drops, which happens one clock after the final burst-ready. A watchdog counter stops a writeback that never starts.

Top module: `snoop_wb_tracker`

## Requirements
- R1: During and after reset, `snoopStrobe`, `snoopInv`, `busy`, `hitFlag`, `hitModFlag`, `beatValid`, `wbDone` and `timeoutErr` are all 0.
- R2: When `inqReq` is 1 in an idle cycle, the block latches `inqAddr` and `inqInv` on that edge. `snoopStrobe` is then 1 for exactly the next cycle. `snoopInv` equals the latched invalidate flag in that cycle and is 0 in every other cycle. `snoopAddr` shows the latched address.
- R3: While `busy` is 1, `inqReq`, `inqAddr` and `inqInv` have no effect. `snoopAddr` keeps the address of the inquire in progress.
- R4: The block samples `cpuHit` and `cpuHitMod` on the RESP_DELAY-th rising edge after the strobe cycle (the 2nd by default) and shows them on `hitFlag` and `hitModFlag` from that edge on. Both flags clear when a new inquire is accepted.
- R5: After a miss, or a hit without modified-hit, `busy` is 0 straight after the sampling edge.
- R6: If `addrHold` is 1 on the edge where `cpuAds` is 1, the burst base is the latched inquire address, and `cpuAddr` is ignored.
- R7: If `addrHold` is 0 on the edge where `cpuAds` is 1, the burst base is `cpuAddr` captured on that edge.
- R8: After the address strobe, `beatValid` is 1 until the fourth `cpuBrdy`. For beat k (0 to 3, advanced by each `cpuBrdy`), `beatAddr` is the base with bits 31:5 kept, bits 4:3 equal to base bits 4:3 XOR k, and bits 2:0 equal to 0. Between ready strobes, `beatAddr` does not change.
- R9: After the last beat, `busy` stays 1 until `cpuHitMod` is sampled 0. On that edge `wbDone` becomes 1 for one cycle and `busy` becomes 0.
- R10: If `cpuAds` is not seen within TIMEOUT_CYC edges after the modified-hit sample, `timeoutErr` is 1 for one cycle and `busy` drops on that same edge. An address strobe on the last allowed edge is still accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inqReq | input | 1 | Request to start an inquire |
| inqAddr | input | ADDR_W | Address to inquire |
| inqInv | input | 1 | Invalidate the line if it hits |
| snoopStrobe | output | 1 | External-address strobe to the processor |
| snoopInv | output | 1 | Invalidate request, valid with the strobe |
| snoopAddr | output | ADDR_W | Latched inquire address |
| addrHold | input | 1 | System is holding the processor off the address bus |
| cpuAds | input | 1 | Processor address strobe that starts the writeback |
| cpuAddr | input | ADDR_W | Processor address bus |
| cpuHit | input | 1 | Processor hit reply |
| cpuHitMod | input | 1 | Processor modified-hit reply |
| cpuBrdy | input | 1 | Burst-ready for one writeback beat |
| hitFlag | output | 1 | Sampled hit |
| hitModFlag | output | 1 | Sampled modified-hit |
| busy | output | 1 | Inquire or writeback in progress |
| beatValid | output | 1 | `beatAddr` is valid for the current beat |
| beatAddr | output | ADDR_W | Address of the current writeback beat |
| wbDone | output | 1 | One-cycle pulse when the writeback has ended |
| timeoutErr | output | 1 | One-cycle pulse when the writeback strobe never arrived |

## Verification
Assertions check on every cycle the properties that depend only on the cycle itself or its neighbour. The strobe is a single cycle, and the invalidate only ever comes with it. `wbDone` and `timeoutErr` are single pulses that come with `busy` falling. A valid beat address holds steady while no ready arrives. The bench scenarios are the only place several other behaviours show up: the exact response sampling edge, the choice of address source under `addrHold`, the interleaved beat order from every start offset, the wait for modified-hit to drop, and where the timeout window ends. Each of these needs a reference address, or a cycle count against the stimulus, that the bench works out.

// File: rtl/snoop_wb_pkg.sv
package snoop_wb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SNOOP_WAIT,
    ST_RESP,
    ST_WB_WAIT_ADS,
    ST_WB_BURST,
    ST_WB_TAIL
  } trkState_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic captureInq;    // latch inquire address/invalidate, clear replies
    logic captureResp;   // sample hit / modified-hit
    logic loadFromLatch; // burst base from latched inquire address
    logic loadFromBus;   // burst base from processor address bus
    logic beatStep;      // advance beat index
  } dpStrobe_t;

endpackage

// File: rtl/snoop_wb_dp.sv
module snoop_wb_dp
  import snoop_wb_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int BEAT_BYTES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobes,
  input  logic [ADDR_W-1:0] inqAddr,
  input  logic              inqInv,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuHit,
  input  logic              cpuHitMod,
  output logic [ADDR_W-1:0] snoopAddr,
  output logic              invReq,
  output logic              hitFlag,
  output logic              hitModFlag,
  output logic [ADDR_W-1:0] beatAddr,
  output logic              lastBeat
);

  localparam int LINE_LSB = $clog2(LINE_BYTES);
  localparam int BEAT_LSB = $clog2(BEAT_BYTES);
  localparam int IDX_W    = LINE_LSB - BEAT_LSB;
  localparam int BEATS    = LINE_BYTES / BEAT_BYTES;

  logic [ADDR_W-1:0] latchAddr;
  logic              latchInv;
  logic [ADDR_W-1:0] baseAddr;
  logic [IDX_W-1:0]  beatIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchAddr  <= '0;
      latchInv   <= 1'b0;
      hitFlag    <= 1'b0;
      hitModFlag <= 1'b0;
    end else begin
      if (strobes.captureInq) begin
        latchAddr  <= inqAddr;
        latchInv   <= inqInv;
        hitFlag    <= 1'b0;
        hitModFlag <= 1'b0;
      end else if (strobes.captureResp) begin
        hitFlag    <= cpuHit;
        hitModFlag <= cpuHitMod;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseAddr <= '0;
      beatIdx  <= '0;
    end else begin
      if (strobes.loadFromLatch) begin
        baseAddr <= latchAddr;
        beatIdx  <= '0;
      end else if (strobes.loadFromBus) begin
        baseAddr <= cpuAddr;
        beatIdx  <= '0;
      end else if (strobes.beatStep) begin
        beatIdx <= beatIdx + 1'b1;
      end
    end
  end

  // interleaved order: start index XOR beat number inside the line
  generate
    if (BEAT_LSB > 0) begin : g_subBeat
      assign beatAddr = {baseAddr[ADDR_W-1:LINE_LSB],
                         baseAddr[LINE_LSB-1:BEAT_LSB] ^ beatIdx,
                         {BEAT_LSB{1'b0}}};
    end else begin : g_byteBeat
      assign beatAddr = {baseAddr[ADDR_W-1:LINE_LSB],
                         baseAddr[LINE_LSB-1:0] ^ beatIdx};
    end
  endgenerate

  assign lastBeat  = (beatIdx == IDX_W'(BEATS - 1));
  assign snoopAddr = latchAddr;
  assign invReq    = latchInv;

endmodule

// File: rtl/snoop_wb_ctrl.sv
module snoop_wb_ctrl
  import snoop_wb_pkg::*;
#(
  parameter int RESP_DELAY  = 2,
  parameter int TIMEOUT_CYC = 64
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      inqReq,
  input  logic      addrHold,
  input  logic      cpuAds,
  input  logic      cpuHitMod,
  input  logic      cpuBrdy,
  input  logic      lastBeat,
  output dpStrobe_t strobes,
  output logic      snoopStrobe,
  output logic      busy,
  output logic      beatValid,
  output logic      wbDone,
  output logic      timeoutErr
);

  localparam int PH_W  = (RESP_DELAY > 1) ? $clog2(RESP_DELAY) : 1;
  localparam int TMR_W = $clog2(TIMEOUT_CYC + 1);

  trkState_e        state, stateNx;
  logic [PH_W-1:0]  phaseCnt;
  logic [TMR_W-1:0] waitTmr;
  logic             phaseEnd, tmrExpire, tailEnd;

  assign phaseEnd  = (phaseCnt == PH_W'(RESP_DELAY - 1));
  assign tmrExpire = (state == ST_WB_WAIT_ADS) && !cpuAds &&
                     (waitTmr == TMR_W'(TIMEOUT_CYC - 1));
  assign tailEnd   = (state == ST_WB_TAIL) && !cpuHitMod;

  always_comb begin
    stateNx = state;
    strobes = '0;
    unique case (state)
      ST_IDLE: begin
        if (inqReq) begin
          strobes.captureInq = 1'b1;
          stateNx = ST_SNOOP_WAIT;
        end
      end
      ST_SNOOP_WAIT: begin
        if (phaseEnd) stateNx = ST_RESP;
      end
      ST_RESP: begin
        strobes.captureResp = 1'b1;
        stateNx = cpuHitMod ? ST_WB_WAIT_ADS : ST_IDLE;
      end
      ST_WB_WAIT_ADS: begin
        if (cpuAds) begin
          strobes.loadFromLatch = addrHold;
          strobes.loadFromBus   = !addrHold;
          stateNx = ST_WB_BURST;
        end else if (tmrExpire) begin
          stateNx = ST_IDLE;
        end
      end
      ST_WB_BURST: begin
        if (cpuBrdy) begin
          strobes.beatStep = 1'b1;
          if (lastBeat) stateNx = ST_WB_TAIL;
        end
      end
      ST_WB_TAIL: begin
        if (tailEnd) stateNx = ST_IDLE;
      end
      default: stateNx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      phaseCnt   <= '0;
      waitTmr    <= '0;
      wbDone     <= 1'b0;
      timeoutErr <= 1'b0;
    end else begin
      state      <= stateNx;
      phaseCnt   <= (state == ST_SNOOP_WAIT && !phaseEnd) ? phaseCnt + 1'b1 : '0;
      waitTmr    <= (state == ST_WB_WAIT_ADS) ? waitTmr + 1'b1 : '0;
      wbDone     <= tailEnd;
      timeoutErr <= tmrExpire;
    end
  end

  assign snoopStrobe = (state == ST_SNOOP_WAIT) && (phaseCnt == '0);
  assign busy        = (state != ST_IDLE);
  assign beatValid   = (state == ST_WB_BURST);

endmodule

// File: rtl/snoop_wb_tracker.sv
module snoop_wb_tracker
  import snoop_wb_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LINE_BYTES  = 32,
  parameter int BEAT_BYTES  = 8,
  parameter int RESP_DELAY  = 2,
  parameter int TIMEOUT_CYC = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inqReq,
  input  logic [ADDR_W-1:0] inqAddr,
  input  logic              inqInv,
  output logic              snoopStrobe,
  output logic              snoopInv,
  output logic [ADDR_W-1:0] snoopAddr,
  input  logic              addrHold,
  input  logic              cpuAds,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuHit,
  input  logic              cpuHitMod,
  input  logic              cpuBrdy,
  output logic              hitFlag,
  output logic              hitModFlag,
  output logic              busy,
  output logic              beatValid,
  output logic [ADDR_W-1:0] beatAddr,
  output logic              wbDone,
  output logic              timeoutErr
);

  dpStrobe_t strobes;
  logic      lastBeat;
  logic      invReq;

  snoop_wb_ctrl #(
    .RESP_DELAY (RESP_DELAY),
    .TIMEOUT_CYC(TIMEOUT_CYC)
  ) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .inqReq     (inqReq),
    .addrHold   (addrHold),
    .cpuAds     (cpuAds),
    .cpuHitMod  (cpuHitMod),
    .cpuBrdy    (cpuBrdy),
    .lastBeat   (lastBeat),
    .strobes    (strobes),
    .snoopStrobe(snoopStrobe),
    .busy       (busy),
    .beatValid  (beatValid),
    .wbDone     (wbDone),
    .timeoutErr (timeoutErr)
  );

  snoop_wb_dp #(
    .ADDR_W    (ADDR_W),
    .LINE_BYTES(LINE_BYTES),
    .BEAT_BYTES(BEAT_BYTES)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .inqAddr   (inqAddr),
    .inqInv    (inqInv),
    .cpuAddr   (cpuAddr),
    .cpuHit    (cpuHit),
    .cpuHitMod (cpuHitMod),
    .snoopAddr (snoopAddr),
    .invReq    (invReq),
    .hitFlag   (hitFlag),
    .hitModFlag(hitModFlag),
    .beatAddr  (beatAddr),
    .lastBeat  (lastBeat)
  );

  assign snoopInv = snoopStrobe & invReq;

endmodule

// File: rtl/snoop_wb_checker.sv
module snoop_wb_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              snoopStrobe,
  input logic              snoopInv,
  input logic              busy,
  input logic              beatValid,
  input logic [ADDR_W-1:0] beatAddr,
  input logic              cpuBrdy,
  input logic              wbDone,
  input logic              timeoutErr
);

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    snoopStrobe |=> !snoopStrobe); // R2

  AST_INV_ONLY_WITH_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    snoopInv |-> snoopStrobe); // R2

  AST_STROBE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    snoopStrobe |-> busy); // R2

  AST_BEAT_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (beatValid && $past(beatValid) && !$past(cpuBrdy)) |-> $stable(beatAddr)); // R8

  AST_BEAT_IN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    beatValid |-> busy); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    wbDone |=> !wbDone); // R9

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    wbDone |-> !busy); // R9

  AST_TIMEOUT_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    timeoutErr |=> !timeoutErr); // R10

  AST_TIMEOUT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    timeoutErr |-> (!busy && !wbDone)); // R10

endmodule

bind snoop_wb_tracker snoop_wb_checker #(.ADDR_W(ADDR_W)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .snoopStrobe(snoopStrobe),
  .snoopInv   (snoopInv),
  .busy       (busy),
  .beatValid  (beatValid),
  .beatAddr   (beatAddr),
  .cpuBrdy    (cpuBrdy),
  .wbDone     (wbDone),
  .timeoutErr (timeoutErr)
);

// File: tb/snoop_wb_tracker_tb_top.sv
module snoop_wb_tracker_tb_top;

  localparam int AW = 32;
  localparam int TO = 64;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inqReq = 1'b0;
  logic [AW-1:0] inqAddr = '0;
  logic          inqInv = 1'b0;
  logic          snoopStrobe, snoopInv;
  logic [AW-1:0] snoopAddr;
  logic          addrHold = 1'b0;
  logic          cpuAds = 1'b0;
  logic [AW-1:0] cpuAddr = '0;
  logic          cpuHit = 1'b0;
  logic          cpuHitMod = 1'b0;
  logic          cpuBrdy = 1'b0;
  logic          hitFlag, hitModFlag, busy, beatValid, wbDone, timeoutErr;
  logic [AW-1:0] beatAddr;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  snoop_wb_tracker #(.ADDR_W(AW), .TIMEOUT_CYC(TO)) dut_i (
    .clk(clk), .rstN(rstN), .inqReq(inqReq), .inqAddr(inqAddr), .inqInv(inqInv),
    .snoopStrobe(snoopStrobe), .snoopInv(snoopInv), .snoopAddr(snoopAddr),
    .addrHold(addrHold), .cpuAds(cpuAds), .cpuAddr(cpuAddr), .cpuHit(cpuHit),
    .cpuHitMod(cpuHitMod), .cpuBrdy(cpuBrdy), .hitFlag(hitFlag),
    .hitModFlag(hitModFlag), .busy(busy), .beatValid(beatValid),
    .beatAddr(beatAddr), .wbDone(wbDone), .timeoutErr(timeoutErr)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [AW-1:0] expBeat(input logic [AW-1:0] base, input int k);
    logic [1:0] idx;
    idx = base[4:3] ^ 2'(k);
    return {base[AW-1:5], idx, 3'b000};
  endfunction

  // d >= 0: address strobe after d idle wait cycles; d < 0: never (timeout)
  task automatic runInquire(input logic [AW-1:0] a, input bit inv, input bit hit,
                            input bit hitm, input bit hold, input logic [AW-1:0] busA,
                            input int d, input bit randWait);
    logic [AW-1:0] base;
    @(negedge clk);
    inqReq = 1'b1; inqAddr = a; inqInv = inv;
    @(negedge clk);
    inqReq = 1'b0;
    chk("R2 strobe", 64'(snoopStrobe), 64'd1);
    chk("R2 inv", 64'(snoopInv), 64'(inv));
    chk("R2 addr", 64'(snoopAddr), 64'(a));
    chk("R4 flag clear", 64'(hitFlag), 64'd0);
    // R3: request while busy must be ignored
    inqReq = 1'b1; inqAddr = ~a; inqInv = ~inv;
    @(negedge clk);
    inqReq = 1'b0;
    chk("R2 strobe one cycle", 64'(snoopStrobe), 64'd0);
    chk("R2 inv off", 64'(snoopInv), 64'd0);
    @(negedge clk);
    cpuHit = hit; cpuHitMod = hitm;
    chk("R4 not yet sampled", 64'({hitFlag, hitModFlag}), 64'd0);
    @(negedge clk);
    cpuHit = 1'b0;
    chk("R4 flags", 64'({hitFlag, hitModFlag}), 64'({hit, hitm}));
    chk("R3 addr kept", 64'(snoopAddr), 64'(a));
    if (!hitm) begin
      chk("R5 idle after clean reply", 64'(busy), 64'd0);
      chk("R3 no second strobe", 64'(snoopStrobe), 64'd0);
      cpuHitMod = 1'b0;
      return;
    end
    chk("R5 busy on modified", 64'(busy), 64'd1);
    addrHold = hold;
    if (d < 0) begin
      for (int i = 0; i < TO - 1; i++) @(negedge clk);
      chk("R10 no early timeout", 64'({timeoutErr, busy}), 64'b01);
      @(negedge clk);
      chk("R10 timeout", 64'({timeoutErr, busy}), 64'b10);
      cpuHitMod = 1'b0; addrHold = 1'b0;
      @(negedge clk);
      chk("R10 pulse", 64'(timeoutErr), 64'd0);
      return;
    end
    for (int i = 0; i < d; i++) @(negedge clk);
    cpuAds = 1'b1;
    cpuAddr = busA;
    @(negedge clk);
    cpuAds = 1'b0;
    cpuAddr = $urandom();
    base = hold ? a : busA;
    for (int k = 0; k < 4; k++) begin
      int w;
      w = randWait ? int'($urandom_range(2)) : 0;
      for (int j = 0; j < w; j++) begin
        chk("R8 stable between ready", 64'(beatAddr), 64'(expBeat(base, k)));
        @(negedge clk);
      end
      chk(hold ? "R6 R8 beat addr latched" : "R7 R8 beat addr bus",
          64'(beatAddr), 64'(expBeat(base, k)));
      chk("R8 beat valid", 64'(beatValid), 64'd1);
      cpuBrdy = 1'b1;
      @(negedge clk);
      cpuBrdy = 1'b0;
    end
    chk("R8 valid ends", 64'(beatValid), 64'd0);
    chk("R9 busy in tail", 64'({busy, wbDone}), 64'b10);
    @(negedge clk);
    cpuHitMod = 1'b0;
    chk("R9 wait for hitmod drop", 64'({busy, wbDone}), 64'b10);
    @(negedge clk);
    chk("R9 done", 64'({busy, wbDone}), 64'b01);
    addrHold = 1'b0;
    @(negedge clk);
    chk("R9 done pulse", 64'(wbDone), 64'd0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1 reset outputs",
        64'({snoopStrobe, snoopInv, busy, hitFlag, hitModFlag, beatValid, wbDone, timeoutErr}),
        64'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", 64'({busy, snoopStrobe}), 64'd0);

    runInquire(32'h1234_5660, 1'b0, 1'b0, 1'b0, 1'b0, '0, 0, 1'b0);           // miss
    runInquire(32'h0BAD_F008, 1'b1, 1'b1, 1'b0, 1'b0, '0, 0, 1'b0);           // clean hit
    runInquire(32'hCAFE_0018, 1'b1, 1'b1, 1'b1, 1'b1, 32'h5555_5550, 2, 1'b0); // R6 start 3
    runInquire(32'hAAAA_0000, 1'b0, 1'b1, 1'b1, 1'b0, 32'h8765_4328, 0, 1'b0); // R7 start 1
    runInquire(32'h0101_0110, 1'b0, 1'b1, 1'b1, 1'b0, 32'h3333_3330, TO - 1, 1'b1); // R10 edge
    runInquire(32'hFEED_0000, 1'b1, 1'b1, 1'b1, 1'b1, '0, -1, 1'b0);          // R10 timeout

    for (int n = 0; n < 40; n++) begin
      logic hitR, modR;
      hitR = 1'($urandom());
      modR = hitR & 1'($urandom());
      runInquire($urandom(), 1'($urandom()), hitR, modR, 1'($urandom()),
                 $urandom(), int'($urandom_range(5)), 1'b1);
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule